// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Periodic Alarm

This block is a small timekeeping peripheral. A free-running 32-bit counter advances on ticks taken from one of four source strobes. Each selected tick can first pass through a prescaler built from two cascaded stages: one divides by 32 and one divides by 512. A periodic-alarm compare value sets how many counter ticks make up one alarm interval. When an interval completes, a status flag sets and can raise an interrupt. The interval then starts again from the current count.

Software reaches the block through a simple synchronous register port with read and write strobes. It can access a control word, a status word and the compare value. A new compare value crosses into the counting logic through a two-flop toggle handshake. A busy bit stays high while the crossing is under way. Source-select and divider fields are locked while the counter runs, so software must stop the counter before it changes them.

Top module: `rtcp_top`

## Requirements
- R1: After a synchronous active-high reset, every register, `count` and `irq` are 0. Reads of any offset other than 0x04, 0x08 and 0x10 return 0.
- R2: The control word at offset 0x04 has these fields: bit 31 run enable, bit 15 alarm enable, bit 14 alarm interrupt enable, bits 13:12 source select, bit 11 divide-by-512 enable, bit 10 divide-by-32 enable. All other bits read as 0.
- R3: While the stored run enable is 1, a control write updates only bits 31, 15 and 14. The source-select and divider fields keep their values.
- R4: A write of source select value 1 is reserved. The previous selection stays in place, while the other fields of that write still apply.
- R5: While running, `count` advances once per tick of the selected `src_tick` bit, divided by 1, 32, 512 or 16384 depending on the divider bits. Ticks on other sources, and all ticks while stopped, are ignored. Stopping the counter clears any partial prescaler count.
- R6: After a compare write at offset 0x10 is accepted, status bit 17 reads 1 for exactly 3 cycles. The new value takes effect as those 3 cycles end.
- R7: A compare write that arrives while status bit 17 is 1 is dropped, and reading offset 0x10 still returns the earlier value.
- R8: With alarm enable set and a nonzero compare value N, status bit 13 sets on every Nth counter tick. The interval restarts at each event, and also whenever a new compare value takes effect.
- R9: Writing 1 to status bit 13 clears it, and writing 0 to it has no effect. A new alarm event in the same cycle as the clear wins.
- R10: `irq` is 1 one cycle after status bit 13, alarm enable and alarm interrupt enable are all 1, and 0 otherwise.
- R11: A compare value of 0 produces no alarm events.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd`, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_tick | input | 4 | One tick strobe per clock source |
| irq | output | 1 | Registered alarm interrupt |
| count | output | 32 | Free-running counter value |

## Verification
The assertions assume `bus_rd` and `bus_wr` are never raised in the same cycle. They also assume software waits for the busy bit to fall before it expects a compare value to land. The bench drives every strobe for a single cycle and never overlaps a read with a write. It applies source ticks only in bursts with a known length, so each expected count and alarm event follows from the tick totals alone.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;

  localparam int OFS_CTRL = 4;
  localparam int OFS_STAT = 8;
  localparam int OFS_CMP  = 16;

  localparam int B_RUN    = 31;
  localparam int B_AEN    = 15;
  localparam int B_AIE    = 14;
  localparam int B_SELHI  = 13;
  localparam int B_SELLO  = 12;
  localparam int B_D512   = 11;
  localparam int B_D32    = 10;

  localparam int B_FLAG   = 13;
  localparam int B_BUSY   = 17;

  localparam logic [1:0] SEL_RSVD = 2'd1;

  typedef struct packed {
    logic       run;
    logic       aen;
    logic       aie;
    logic [1:0] sel;
    logic       d512;
    logic       d32;
  } ctl_t;

  function automatic logic [31:0] pack_ctl(ctl_t c);
    logic [31:0] w;
    w = '0;
    w[B_RUN]           = c.run;
    w[B_AEN]           = c.aen;
    w[B_AIE]           = c.aie;
    w[B_SELHI:B_SELLO] = c.sel;
    w[B_D512]          = c.d512;
    w[B_D32]           = c.d32;
    return w;
  endfunction

  function automatic logic [31:0] pack_stat(logic flag, logic busy);
    logic [31:0] w;
    w = '0;
    w[B_FLAG] = flag;
    w[B_BUSY] = busy;
    return w;
  endfunction

endpackage

// File: rtl/rtcp_divstage.sv
module rtcp_divstage #(
  parameter int RATIO = 32,
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bypass,
  input  logic tick_in,
  output logic tick_out
);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] phase;

  assign tick_out = bypass ? tick_in : (tick_in && (phase == LAST));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= '0;
    end else if (!bypass && tick_in) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  // R5
  stage_src_chk: assert property (@(posedge clk) disable iff (rst)
    tick_out |-> tick_in);

endmodule

// File: rtl/rtcp_prescale.sv
module rtcp_prescale #(
  parameter int SEL_W = 2,
  parameter int DIV_A = 32,
  parameter int DIV_B = 512,
  localparam int NSRC = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic             div_a_en,
  input  logic             div_b_en,
  input  logic [NSRC-1:0]  src_tick,
  output logic             tick
);
  localparam int NSTG = 2;

  logic [NSTG:0]   chain;
  logic [NSTG-1:0] byp;
  logic            sel_tick;

  assign sel_tick = src_tick[sel];
  assign chain[0] = sel_tick && run;
  assign byp[0]   = !div_a_en;
  assign byp[1]   = !div_b_en;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    localparam int R = (g == 0) ? DIV_A : DIV_B;
    rtcp_divstage #(.RATIO(R)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .clr      (!run),
      .bypass   (byp[g]),
      .tick_in  (chain[g]),
      .tick_out (chain[g+1])
    );
  end

  assign tick = chain[NSTG];

  // R5
  cascade_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> (run && sel_tick));

endmodule

// File: rtl/rtcp_cmp_sync.sv
module rtcp_cmp_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         busy,
  output logic         commit,
  output logic [W-1:0] pend,
  output logic [W-1:0] act
);
  logic req, s1, s2, s3;
  logic wr_ok;

  assign busy   = req ^ s3;
  assign commit = s2 ^ s3;
  assign wr_ok  = wr && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      pend <= '0;
    end else if (wr_ok) begin
      req  <= ~req;
      pend <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      s3  <= 1'b0;
      act <= '0;
    end else begin
      s1 <= req;
      s2 <= s1;
      s3 <= s2;
      if (commit) act <= pend;
    end
  end

  // R7
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && busy) |=> $stable(pend));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && $past(busy) && $past(busy, 2) && $past(busy, 3)));

  // R6
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> busy);

endmodule

// File: rtl/rtcp_core.sv
module rtcp_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             aen,
  input  logic             restart,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] count,
  output logic             evt
);
  logic [CNT_W-1:0] intv;
  logic             armed;

  assign armed = aen && (cmp != '0);
  assign evt   = tick && armed && (intv == cmp - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (tick) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !armed) begin
      intv <= '0;
    end else if (tick) begin
      intv <= evt ? '0 : intv + 1'b1;
    end
  end

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

endmodule

// File: rtl/rtcp_regs.sv
module rtcp_regs
  import rtcp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              evt,
  input  logic              busy,
  input  logic [31:0]       cmp_pend,
  output ctl_t              ctl,
  output logic              cmp_wr,
  output logic              flag,
  output logic              irq,
  output logic [31:0]       bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFS_CMP);

  logic ctl_wr, stat_wr, clr_req;

  assign ctl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign cmp_wr  = bus_wr && (bus_addr == A_CMP);
  assign clr_req = stat_wr && bus_wdata[B_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (ctl_wr) begin
      ctl.run <= bus_wdata[B_RUN];
      ctl.aen <= bus_wdata[B_AEN];
      ctl.aie <= bus_wdata[B_AIE];
      if (!ctl.run) begin
        ctl.d512 <= bus_wdata[B_D512];
        ctl.d32  <= bus_wdata[B_D32];
        if (bus_wdata[B_SELHI:B_SELLO] != SEL_RSVD) begin
          ctl.sel <= bus_wdata[B_SELHI:B_SELLO];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (evt) begin
      flag <= 1'b1;
    end else if (clr_req) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= flag && ctl.aen && ctl.aie;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= pack_ctl(ctl);
        A_STAT:  bus_rdata <= pack_stat(flag, busy);
        A_CMP:   bus_rdata <= cmp_pend;
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R3
  lock_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.run |=> ($stable(ctl.sel) && $stable(ctl.d512) && $stable(ctl.d32)));

  // R4
  sel_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.sel != SEL_RSVD);

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag);

  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_req) |=> flag);

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/rtcp_top.sv
module rtcp_top
  import rtcp_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SEL_W  = 2,
  parameter int DIV_A  = 32,
  parameter int DIV_B  = 512,
  localparam int NSRC  = 1 << SEL_W,
  localparam int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_tick,
  output logic              irq,
  output logic [CNT_W-1:0]  count
);
  ctl_t             ctl;
  logic             cmp_wr, busy, commit, evt, flag, tick;
  logic [CNT_W-1:0] cmp_pend, cmp_act;

  rtcp_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt       (evt),
    .busy      (busy),
    .cmp_pend  (cmp_pend),
    .ctl       (ctl),
    .cmp_wr    (cmp_wr),
    .flag      (flag),
    .irq       (irq),
    .bus_rdata (bus_rdata)
  );

  rtcp_prescale #(.SEL_W(SEL_W), .DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (ctl.run),
    .sel      (ctl.sel),
    .div_a_en (ctl.d32),
    .div_b_en (ctl.d512),
    .src_tick (src_tick),
    .tick     (tick)
  );

  rtcp_cmp_sync #(.W(CNT_W)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .wr     (cmp_wr),
    .wdata  (bus_wdata),
    .busy   (busy),
    .commit (commit),
    .pend   (cmp_pend),
    .act    (cmp_act)
  );

  rtcp_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .aen     (ctl.aen),
    .restart (commit),
    .cmp     (cmp_act),
    .count   (count),
    .evt     (evt)
  );

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag && ctl.aie));

  // R11
  zero_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(cmp_act) != '0));

endmodule

// File: tb/rtcp_top_test.sv
module rtcp_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL = 5'h04;
  localparam logic [4:0] A_STAT = 5'h08;
  localparam logic [4:0] A_CMP  = 5'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = '0;
  logic        irq;
  logic [31:0] count;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtcp_top uut (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_tick  (src_tick),
    .irq       (irq),
    .count     (count)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read value once data is registered
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        chk("R12 unexpected read data", bus_rdata, 32'hx);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(logic [3:0] mask, int n);
    @(negedge clk);
    src_tick = mask;
    repeat (n) @(posedge clk);
    @(negedge clk);
    src_tick = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state and undefined offsets
    chk("R1 count after reset", count, 0);
    chk("R1 irq after reset", {31'd0, irq}, 0);
    rd(A_CTRL, 0, "R1 ctrl reset");
    rd(A_STAT, 0, "R1 stat reset");
    rd(A_CMP,  0, "R1 cmp reset");
    rd(5'h00,  0, "R1 offset 0x00");
    rd(5'h0C,  0, "R1 offset 0x0C");
    rd(5'h1C,  0, "R12 offset 0x1C");

    // R2 field map
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, 32'h8000_FC00, "R2 ctrl readback");

    // R3 lock while running
    wr(A_CTRL, 32'h8000_C000);
    rd(A_CTRL, 32'h8000_FC00, "R3 fields locked");
    wr(A_CTRL, 32'h0000_0000);
    rd(A_CTRL, 32'h0000_3C00, "R3 stop keeps fields");
    wr(A_CTRL, 32'h0000_0000);
    rd(A_CTRL, 32'h0000_0000, "R3 fields writable when stopped");

    // R4 reserved source
    wr(A_CTRL, 32'h0000_2000);
    wr(A_CTRL, 32'h0000_1C00);
    rd(A_CTRL, 32'h0000_2C00, "R4 reserved select ignored");
    wr(A_CTRL, 32'h0000_3000);
    rd(A_CTRL, 32'h0000_3000, "R4 select 3 accepted");

    // R5 counting and ratios
    wr(A_CTRL, 32'h8000_2000);
    pulse(4'b0101, 10);
    chk("R5 div1 count", count, 10);
    pulse(4'b0001, 7);
    chk("R5 other source ignored", count, 10);
    wr(A_CTRL, 32'h0000_2000);
    pulse(4'b0100, 5);
    chk("R5 stopped ignored", count, 10);
    wr(A_CTRL, 32'h0000_2400);
    wr(A_CTRL, 32'h8000_2400);
    pulse(4'b0100, 64);
    chk("R5 div32 count", count, 12);
    pulse(4'b0100, 31);
    chk("R5 div32 partial", count, 12);
    wr(A_CTRL, 32'h0000_2400);
    wr(A_CTRL, 32'h0000_2800);
    wr(A_CTRL, 32'h8000_2800);
    pulse(4'b0100, 1024);
    chk("R5 div512 count", count, 14);
    wr(A_CTRL, 32'h0000_2800);
    wr(A_CTRL, 32'h0000_2C00);
    wr(A_CTRL, 32'h8000_2C00);
    pulse(4'b0100, 16383);
    chk("R5 cascade one short", count, 14);
    pulse(4'b0100, 1);
    chk("R5 cascade 16384", count, 15);
    wr(A_CTRL, 32'h0000_0000);
    wr(A_CTRL, 32'h0000_0000);
    wr(A_CTRL, 32'h8000_0000);

    // R6 busy window
    wr(A_CMP, 32'd5);
    rd(A_STAT, 32'h0002_0000, "R6 busy after write");
    idle(3);
    rd(A_STAT, 32'h0000_0000, "R6 busy released");
    rd(A_CMP, 32'd5, "R6 compare readback");

    // R7 drop while busy
    wr(A_CMP, 32'd9);
    wr(A_CMP, 32'd7);
    idle(4);
    rd(A_CMP, 32'd9, "R7 write during busy dropped");
    wr(A_CMP, 32'd5);
    idle(4);

    // R8 periodic alarm
    wr(A_CTRL, 32'h8000_C000);
    pulse(4'b0001, 4);
    rd(A_STAT, 32'h0000_0000, "R8 no flag before interval");
    chk("R10 irq low before event", {31'd0, irq}, 0);
    pulse(4'b0001, 1);
    rd(A_STAT, 32'h0000_2000, "R8 flag at interval");
    chk("R10 irq high", {31'd0, irq}, 1);

    // R9 clear behaviour
    wr(A_STAT, 32'h0000_0000);
    rd(A_STAT, 32'h0000_2000, "R9 write 0 no effect");
    wr(A_STAT, 32'h0000_2000);
    rd(A_STAT, 32'h0000_0000, "R9 write 1 clears");
    chk("R10 irq follows clear", {31'd0, irq}, 0);
    pulse(4'b0001, 5);
    rd(A_STAT, 32'h0000_2000, "R8 periodic restart");

    // R10 gating
    wr(A_CTRL, 32'h8000_8000);
    idle(1);
    chk("R10 irq masked by enable", {31'd0, irq}, 0);
    rd(A_STAT, 32'h0000_2000, "R10 flag kept while masked");
    wr(A_CTRL, 32'h8000_C000);
    idle(2);
    chk("R10 irq unmasked", {31'd0, irq}, 1);
    wr(A_STAT, 32'h0000_2000);

    // R11 zero compare
    wr(A_CMP, 32'd0);
    idle(4);
    pulse(4'b0001, 40);
    rd(A_STAT, 32'h0000_0000, "R11 zero compare no event");
    chk("R11 irq stays low", {31'd0, irq}, 0);

    idle(3);
    summary();
  end

endmodule